// File: doc/BRIEF.md
# Line Transmit Test-Pattern Selector

This block sits on the transmit side of a DS3, E3 or STS-1 line port, ahead of line coding. On every transmit line clock it sends one bit, chosen by two select inputs (`sel_a`, `sel_b`) together with two line-mode inputs (`mode_e3`, `mode_sts`). The bit can be the user's serial data, a steady stream of ones, a DS3 alarm indication signal (AIS), a repeating 1,0,0 sequence, or a pseudo-random bit sequence. The length of that sequence follows the line standard.

The line-mode inputs are sampled only while both select inputs are low. While a test pattern or alarm is being sent, the mode in force stays fixed. To move a running pattern to another line standard, the caller returns the selects to 00 for at least one cycle and then selects the pattern again. Every generator restarts from its first bit whenever it becomes the active source.

The DS3 AIS is a simplified M-frame of 4760 bits: 7 subframes, each of 8 blocks, each block being 85 bits (one overhead bit followed by 84 payload bits). The output is registered, so every selection has the same one-cycle latency.

Top module: `tx_pattern_sel`

## Requirements
- R1: With `sel_a`=0 and `sel_b`=0, `data_out` equals the `data_in` value sampled at the previous rising clock edge, in every line mode.
- R2: With `sel_a`=0, `sel_b`=1 and the mode in force being E3 (`mode_e3`=1) or STS-1 (`mode_sts`=1, `mode_e3`=0), `data_out` is 1 on every cycle.
- R3: With `sel_a`=0, `sel_b`=1 and the mode in force being DS3 (both mode bits 0), the block sends a 4760-bit frame of 7 subframes × 8 blocks × 85 bits. Bit 0 of each block is overhead. Payload bit p (1..84) of a block is 1 when p is odd. Overhead values:
  - block 0 of subframes 0 and 1 is 1; block 0 of subframes 2, 3 and 4 is 0; block 0 of subframe 5 is 1; block 0 of subframe 6 is 0;
  - blocks 1 and 7 carry 1;
  - blocks 2 through 6 carry 0.
- R4: With `sel_a`=1 and `sel_b`=0, `data_out` repeats 1,0,0 starting with 1, in every line mode.
- R5: With both selects 1 and E3 in force, `data_out` is the output o of the x^23+x^18+1 sequence: o(k)=1 for k<23, otherwise o(k)=o(k-23) XOR o(k-18).
- R6: With both selects 1 and DS3 or STS-1 in force, `data_out` follows o(k)=1 for k<15, otherwise o(k)=o(k-15) XOR o(k-14) (x^15+x^14+1).
- R7: The mode bits are captured only in cycles where both selects are 0. A mode change made while a select is 1, including in the very cycle the selects leave 00, has no effect until the selects have been 00 for one cycle.
- R8: Whenever the selected source differs from the source of the previous cycle, the pattern restarts from its first bit (k=0).
- R9: While `rst_n` is low, `data_out` is 0 and the mode in force becomes DS3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit line clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_a | input | 1 | Pattern select, upper bit |
| sel_b | input | 1 | Pattern select, lower bit |
| mode_e3 | input | 1 | E3 line mode request |
| mode_sts | input | 1 | STS-1 line mode request (used when `mode_e3`=0) |
| data_in | input | 1 | User serial transmit data |
| data_out | output | 1 | Registered serial output |

## Verification
Two events can fall in the same cycle: a line-mode change and a change of the select bits. The bench drives both on one edge in two cases. In the first, the mode flips in the cycle the selects leave 00. In the second, the mode flips together with the return to 00. The bench then judges from the bit stream which pseudo-random sequence follows, over more than 23 bits, because the first 15 bits of both sequences are all ones. A source change can also coincide with a generator that is part-way through its cycle. The bench checks this by re-selecting the alarm frame and the short sequence mid-stream and comparing against bit 0 of each.

// File: rtl/tx_pat_pkg.sv
// Shared types for the transmit test-pattern selector.
// Assumes: one source is active per line clock.
package tx_pat_pkg;

    typedef enum logic [2:0] {
        SRC_USER       = 3'd0,
        SRC_ONES       = 3'd1,
        SRC_AIS        = 3'd2,
        SRC_P100       = 3'd3,
        SRC_PRBS_LONG  = 3'd4,
        SRC_PRBS_SHORT = 3'd5
    } tx_src_e;

endpackage

// File: rtl/tx_src_decode.sv
// Maps the select pair and the mode in force to one output source.
// Assumes: the mode inputs are the held values, not the raw pins.
module tx_src_decode
    import tx_pat_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       e3,
    input  logic       sts,
    output tx_src_e    src
);

    // Pick the source from select and mode.
    always_comb begin
        unique case (sel)
            2'b00: src = SRC_USER;
            2'b01: src = (e3 || sts) ? SRC_ONES : SRC_AIS;
            2'b10: src = SRC_P100;
            default: src = e3 ? SRC_PRBS_LONG : SRC_PRBS_SHORT;
        endcase
    end

endmodule

// File: rtl/tx_prbs_gen.sv
// Fibonacci pseudo-random generator, polynomial x^LEN + x^TAP + 1.
// Assumes: load restarts from the all-ones seed in the same cycle; en advances.
module tx_prbs_gen #(
    parameter int LEN = 15,
    parameter int TAP = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en,
    output logic bit_o
);

    logic [LEN-1:0] st_q;
    logic [LEN-1:0] cur;
    logic           fb;

    // Current state: the seed on load, else the stored state.
    always_comb begin
        cur   = load ? {LEN{1'b1}} : st_q;
        bit_o = cur[LEN-1];
        fb    = cur[LEN-1] ^ cur[TAP-1];
    end

    // Advance the shift register while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= {LEN{1'b1}};
        end else if (en) begin
            st_q <= {cur[LEN-2:0], fb};
        end
    end

endmodule

// File: rtl/tx_p100_gen.sv
// Repeating 1,0,0 generator.
// Assumes: load restarts at the leading 1 in the same cycle.
module tx_p100_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en,
    output logic bit_o
);

    logic [1:0] ph_q;
    logic [1:0] ph_c;

    // Phase in use this cycle and its output bit.
    always_comb begin
        ph_c  = load ? 2'd0 : ph_q;
        bit_o = (ph_c == 2'd0);
    end

    // Step the phase 0,1,2,0 while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= 2'd0;
        end else if (en) begin
            ph_q <= (ph_c == 2'd2) ? 2'd0 : ph_c + 2'd1;
        end
    end

endmodule

// File: rtl/tx_ds3_ais_gen.sv
// Simplified DS3 alarm frame generator: SUBFRAMES x BLOCKS x BLOCK_BITS bits.
// Bit 0 of every block is overhead; the payload alternates and starts at 1.
// Assumes: the overhead layout below is written for 7 subframes of 8 blocks.
module tx_ds3_ais_gen #(
    parameter int BLOCK_BITS = 85,
    parameter int BLOCKS     = 8,
    parameter int SUBFRAMES  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic en,
    output logic bit_o
);

    localparam int PW = $clog2(BLOCK_BITS);
    localparam int BW = $clog2(BLOCKS);
    localparam int SW = $clog2(SUBFRAMES);
    localparam logic [PW-1:0] POS_LAST = PW'(BLOCK_BITS - 1);
    localparam logic [BW-1:0] BLK_LAST = BW'(BLOCKS - 1);
    localparam logic [SW-1:0] SUB_LAST = SW'(SUBFRAMES - 1);

    logic [PW-1:0] pos_q, pos_c;
    logic [BW-1:0] blk_q, blk_c;
    logic [SW-1:0] sub_q, sub_c;

    // Overhead bit value for a given subframe and block.
    function automatic logic ovh_bit(input int s, input int b);
        logic v;
        if (b == 0) begin
            // Block 0 holds the alarm, parity and alignment bits.
            v = (s == 0) || (s == 1) || (s == 5);
        end else begin
            // Blocks 1 and 7 are ones, the rest are zero.
            v = (b == 1) || (b == 7);
        end
        return v;
    endfunction

    // Frame position in use this cycle and the bit it yields.
    always_comb begin
        pos_c = load ? '0 : pos_q;
        blk_c = load ? '0 : blk_q;
        sub_c = load ? '0 : sub_q;
        if (pos_c == '0) begin
            bit_o = ovh_bit(int'(sub_c), int'(blk_c));
        end else begin
            bit_o = pos_c[0];
        end
    end

    // Advance bit, block and subframe counters while selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            blk_q <= '0;
            sub_q <= '0;
        end else if (en) begin
            if (pos_c == POS_LAST) begin
                pos_q <= '0;
                if (blk_c == BLK_LAST) begin
                    blk_q <= '0;
                    sub_q <= (sub_c == SUB_LAST) ? '0 : sub_c + 1'b1;
                end else begin
                    blk_q <= blk_c + 1'b1;
                    sub_q <= sub_c;
                end
            end else begin
                pos_q <= pos_c + 1'b1;
                blk_q <= blk_c;
                sub_q <= sub_c;
            end
        end
    end

endmodule

// File: rtl/tx_pattern_sel.sv
// Transmit test-pattern selector: chooses user data or a generated pattern
// per line clock and registers the result (one-cycle latency).
// Assumes: mode bits are captured only while both selects are low.
module tx_pattern_sel
    import tx_pat_pkg::*;
#(
    parameter int PRBS_LONG_LEN  = 23,
    parameter int PRBS_LONG_TAP  = 18,
    parameter int PRBS_SHORT_LEN = 15,
    parameter int PRBS_SHORT_TAP = 14,
    parameter int AIS_BLOCK_BITS = 85,
    parameter int AIS_BLOCKS     = 8,
    parameter int AIS_SUBFRAMES  = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_a,
    input  logic sel_b,
    input  logic mode_e3,
    input  logic mode_sts,
    input  logic data_in,
    output logic data_out
);

    logic [1:0] sel;
    logic       idle;
    logic       e3_q;
    logic       sts_q;
    tx_src_e    src;
    tx_src_e    src_q;
    logic       fresh;
    logic       b_long, b_short, b_ais, b_p100;
    logic       nxt;

    assign sel  = {sel_a, sel_b};
    assign idle = (sel == 2'b00);

    // Hold the line mode; take new values only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e3_q  <= 1'b0;
            sts_q <= 1'b0;
        end else if (idle) begin
            e3_q  <= mode_e3;
            sts_q <= mode_sts;
        end
    end

    tx_src_decode u_dec (
        .sel (sel),
        .e3  (e3_q),
        .sts (sts_q),
        .src (src)
    );

    // Remember last cycle's source to spot a new selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= SRC_USER;
        end else begin
            src_q <= src;
        end
    end

    assign fresh = (src != src_q);

    tx_prbs_gen #(.LEN(PRBS_LONG_LEN), .TAP(PRBS_LONG_TAP)) u_prbs_long (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fresh && (src == SRC_PRBS_LONG)),
        .en    (src == SRC_PRBS_LONG),
        .bit_o (b_long)
    );

    tx_prbs_gen #(.LEN(PRBS_SHORT_LEN), .TAP(PRBS_SHORT_TAP)) u_prbs_short (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fresh && (src == SRC_PRBS_SHORT)),
        .en    (src == SRC_PRBS_SHORT),
        .bit_o (b_short)
    );

    tx_ds3_ais_gen #(
        .BLOCK_BITS (AIS_BLOCK_BITS),
        .BLOCKS     (AIS_BLOCKS),
        .SUBFRAMES  (AIS_SUBFRAMES)
    ) u_ais (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fresh && (src == SRC_AIS)),
        .en    (src == SRC_AIS),
        .bit_o (b_ais)
    );

    tx_p100_gen u_p100 (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (fresh && (src == SRC_P100)),
        .en    (src == SRC_P100),
        .bit_o (b_p100)
    );

    // Multiplex the active source.
    always_comb begin
        unique case (src)
            SRC_USER:       nxt = data_in;
            SRC_ONES:       nxt = 1'b1;
            SRC_AIS:        nxt = b_ais;
            SRC_P100:       nxt = b_p100;
            SRC_PRBS_LONG:  nxt = b_long;
            SRC_PRBS_SHORT: nxt = b_short;
            default:        nxt = 1'b0;
        endcase
    end

    // Output register: fixed one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= 1'b0;
        end else begin
            data_out <= nxt;
        end
    end

endmodule

// File: rtl/tx_pattern_sel_chk.sv
// Property checker for the transmit test-pattern selector, bound to the top.
// Assumes: e3_q/sts_q are the mode in force inside the top.
module tx_pattern_sel_chk (
    input logic clk,
    input logic rst_n,
    input logic sel_a,
    input logic sel_b,
    input logic data_in,
    input logic data_out,
    input logic e3_q,
    input logic sts_q
);

    logic       c_p100, c_long, c_short;
    logic [5:0] r_p100_q, r_long_q, r_short_q;
    logic [5:0] r_p100, r_long, r_short;

    // Conditions under which each repeating source runs.
    always_comb begin
        c_p100  = sel_a && !sel_b;
        c_long  = sel_a && sel_b && e3_q;
        c_short = sel_a && sel_b && !e3_q;
        r_p100  = c_p100  ? ((r_p100_q  == 6'd63) ? 6'd63 : r_p100_q  + 6'd1) : 6'd0;
        r_long  = c_long  ? ((r_long_q  == 6'd63) ? 6'd63 : r_long_q  + 6'd1) : 6'd0;
        r_short = c_short ? ((r_short_q == 6'd63) ? 6'd63 : r_short_q + 6'd1) : 6'd0;
    end

    // Count consecutive cycles each source has run since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_p100_q  <= 6'd0;
            r_long_q  <= 6'd0;
            r_short_q <= 6'd0;
        end else begin
            r_p100_q  <= r_p100;
            r_long_q  <= r_long;
            r_short_q <= r_short;
        end
    end

    // R1
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a && !sel_b) |=> (data_out == $past(data_in)));

    // R2
    ones_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a && sel_b && (e3_q || sts_q)) |=> data_out);

    // R4
    period_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_p100 >= 6'd4) |=> (data_out == $past(data_out, 3)));

    // R5
    long_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_long >= 6'd24) |=> (data_out == ($past(data_out, 23) ^ $past(data_out, 18))));

    // R6
    short_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_short >= 6'd16) |=> (data_out == ($past(data_out, 15) ^ $past(data_out, 14))));

endmodule

bind tx_pattern_sel tx_pattern_sel_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .data_in  (data_in),
    .data_out (data_out),
    .e3_q     (e3_q),
    .sts_q    (sts_q)
);

// File: tb/tx_pattern_sel_tb.sv
module tx_pattern_sel_tb;

    localparam int CLK_PERIOD = 10;
    localparam int FRAME_BITS = 4760;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_a = 1'b0, sel_b = 1'b0, mode_e3 = 1'b0, mode_sts = 1'b0, data_in = 1'b0;
    logic data_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [22:0] hist;
    int seq_k;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tx_pattern_sel u_dut (
        .clk(clk), .rst_n(rst_n), .sel_a(sel_a), .sel_b(sel_b),
        .mode_e3(mode_e3), .mode_sts(mode_sts), .data_in(data_in), .data_out(data_out)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: data_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle at a falling edge and compare at the next falling edge.
    task automatic step(input logic a, input logic b, input logic e3, input logic sts,
                        input logic din, input logic exp, input string req);
        sel_a = a; sel_b = b; mode_e3 = e3; mode_sts = sts; data_in = din;
        @(negedge clk);
        check(data_out, exp, req);
    endtask

    // One idle cycle that also sets the mode (user data shows through).
    task automatic idle_mode(input logic e3, input logic sts);
        step(1'b0, 1'b0, e3, sts, 1'b1, 1'b1, "R1");
    endtask

    function automatic logic ais_bit(input int k);
        int sub, r, blk, pos;
        sub = k / 680; r = k % 680; blk = r / 85; pos = r % 85;
        if (pos != 0) return (pos % 2 == 1);
        if (blk == 0) return (sub == 0) || (sub == 1) || (sub == 5);
        return (blk == 1) || (blk == 7);
    endfunction

    // Next bit of a sequence with o(k)=o(k-n)^o(k-t), first n bits ones.
    function automatic logic seq_next(input int n, input int t);
        logic o;
        if (seq_k < n) o = 1'b1;
        else o = hist[n-1] ^ hist[t-1];
        hist = {hist[21:0], o};
        seq_k++;
        return o;
    endfunction

    task automatic run_seq(input logic e3, input logic sts, input int n, input int t,
                           input int len, input string req);
        seq_k = 0; hist = '0;
        for (int i = 0; i < len; i++) begin
            logic e;
            e = seq_next(n, t);
            step(1'b1, 1'b1, e3, sts, 1'b0, e, req);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(data_out, 1'b0, "R9");
        rst_n = 1'b1;
        // R9: mode after reset is DS3, so 01 gives the alarm frame bit 0
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ais_bit(0), "R9");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ais_bit(1), "R9");

        // R1: pass-through in all four mode combinations
        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 40; i++) begin
                logic d;
                d = ((i * 7 + m * 3) % 5) < 2;
                step(1'b0, 1'b0, m[1], m[0], d, d, "R1");
            end
        end

        // R2: all ones in E3 and in STS-1
        idle_mode(1'b1, 1'b0);
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R2");
        idle_mode(1'b0, 1'b1);
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R2");

        // R3: alarm frame in DS3, one full frame plus the start of the next
        idle_mode(1'b0, 1'b0);
        for (int k = 0; k < FRAME_BITS + 200; k++)
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ais_bit(k % FRAME_BITS), "R3");

        // R4: 1,0,0 in every mode
        for (int m = 0; m < 4; m++) begin
            idle_mode(m[1], m[0]);
            for (int k = 0; k < 30; k++) step(1'b1, 1'b0, m[1], m[0], 1'b1, (k % 3) == 0, "R4");
        end

        // R5: long sequence in E3
        idle_mode(1'b1, 1'b0);
        run_seq(1'b1, 1'b0, 23, 18, 400, "R5");
        // R6: short sequence in DS3 and STS-1
        idle_mode(1'b0, 1'b0);
        run_seq(1'b0, 1'b0, 15, 14, 400, "R6");
        idle_mode(1'b0, 1'b1);
        run_seq(1'b0, 1'b1, 15, 14, 400, "R6");

        // R7: mode flip while running is held; short sequence continues
        idle_mode(1'b0, 1'b0);
        seq_k = 0; hist = '0;
        for (int i = 0; i < 60; i++) begin
            logic e;
            e = seq_next(15, 14);
            step(1'b1, 1'b1, (i >= 5), 1'b0, 1'b0, e, "R7");
        end
        // R7: return to 00 with E3 at the same edge is taken, long sequence next
        idle_mode(1'b1, 1'b0);
        run_seq(1'b1, 1'b0, 23, 18, 60, "R7");
        // R7: mode flip in the cycle the selects leave 00 is not taken
        idle_mode(1'b0, 1'b0);
        run_seq(1'b1, 1'b0, 15, 14, 60, "R7");

        // R8: re-selection restarts the short sequence mid-stream
        idle_mode(1'b0, 1'b0);
        run_seq(1'b0, 1'b0, 15, 14, 37, "R8");
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, (k % 3) == 0, "R8");
        run_seq(1'b0, 1'b0, 15, 14, 50, "R8");
        // R8: alarm frame restarts from bit 0 after a detour
        idle_mode(1'b0, 1'b0);
        for (int k = 0; k < 130; k++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ais_bit(k), "R8");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, (k % 3) == 0, "R8");
        for (int k = 0; k < 100; k++) step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ais_bit(k), "R8");
        // R8: 1,0,0 restarts at its leading 1 after two bits
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        for (int k = 0; k < 2; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, (k % 3) == 0, "R8");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, ais_bit(0), "R8");
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, (k % 3) == 0, "R8");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: data_out=%b expected=finish", data_out);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule